// File: doc/BRIEF.md
# Floating-Point Compare Condition Generator

This block compares two IEEE-754 operands, either both single precision or both double precision. It returns a 32-bit condition word in one registered step. The word carries the basic ordering outcome and the predicates derived from it, including those that are also true when the operands are unordered. It also carries four interval bits. These tell whether the first operand lies inside the closed range from zero to the second operand, lies outside it, or sits on one of its ends. Besides the word, the block raises an invalid-operation flag when a NaN takes part in the compare.

A request is a single-cycle strobe. It carries the two operands, a width select, a compare-kind select and a legacy-mode select. The compare kind is either ordinary or quiet-on-unordered. Legacy mode suppresses the six unordered-combination predicates. The request also carries the index of a destination register. The result appears on the cycle after the strobe, with a write enable that stays low when the destination index is zero. A register file beside the block takes the word through that write enable.

Top module: `fcmp_cond_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. If either operand is a NaN, the condition word is exactly 0x3D009: bits 0 (unordered), 3 (not equal), 12, 14, 15, 16 and 17 set, with no interval bits (8 to 11).
- R2: `invalid_flag` is raised with a result only when a NaN is present. For an ordinary compare (`quiet_sel`=0), any NaN raises it. For a quiet compare (`quiet_sel`=1), only the first NaN found counts, with s1 examined before s2, and it must be signaling (fraction MSB clear) to raise the flag. A quiet NaN in s1 therefore hides a signaling NaN in s2.
- R3: For ordered operands, before the interval bits are merged, the word is 0x290A6 when s1 equals s2, 0x1A06A when s1 < s2 and 0x2609A when s1 > s2. Positive and negative zero compare equal, and infinities order beyond every finite value.
- R4: With `legacy_sel`=1, bits 17:12 of the word are zero and every other bit is unchanged.
- R5: The interval bits 11:8 are all zero when the result is unordered or when s2's sign bit is set. This includes s2 = -0.
- R6: With an ordered result and s2's sign clear: if s1 equals s2, or s1 is zero of either sign, bits 9 and 11 are set and bits 8 and 10 are clear.
- R7: With an ordered result and s2's sign clear, and outside the R6 cases: if s1 > s2, or s1 is negative, bits 8 and 11 are set. Otherwise (0 < s1 < s2) bits 9 and 10 are set.
- R8: `dbl_sel`=1 compares all 64 bits as double precision. `dbl_sel`=0 compares bits 31:0 as single precision, and bits 63:32 of both operands have no effect.
- R9: The outputs follow the strobe by one clock. `wr_en` is high exactly when the strobe was high and `dst_idx` was nonzero. `dst_out` echoes the index. `invalid_flag` and `wr_en` are low on cycles without a strobe, while `cond_word` and `dst_out` hold. Bits 31:18 of the word are always zero.
- R10: A synchronous active-high `rst` clears all outputs, even while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| s1_in | input | 64 | First operand (single precision in bits 31:0) |
| s2_in | input | 64 | Second operand (single precision in bits 31:0) |
| dbl_sel | input | 1 | 1 = double precision, 0 = single |
| quiet_sel | input | 1 | 1 = quiet-on-unordered compare, 0 = ordinary |
| legacy_sel | input | 1 | 1 = suppress bits 17:12 |
| dst_idx | input | 5 | Destination register index |
| cond_word | output | 32 | Registered condition word |
| invalid_flag | output | 1 | Invalid-operation flag for the request |
| wr_en | output | 1 | Write enable for the destination |
| dst_out | output | 5 | Registered destination index |

## Verification
The hardest case to reach is the quiet compare in which s1 is a quiet NaN and s2 is a signaling NaN. Here the flag must stay low because s1 is examined first. Uniform random bit patterns almost never produce two NaNs at once. The stimulus therefore draws each operand from weighted classes (signed zeros, infinities, quiet and signaling NaNs with random payloads, and values near one). It also copies or sign-flips s1 into s2 so that equality and the zero-boundary interval cases occur often. Directed requests then pin down the exact NaN pairing, the s2 = -0 case and single-precision operands carrying junk in their upper halves.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int unsigned OPW   = 64;
  localparam int unsigned CW    = 32;
  localparam int unsigned IDX_W = 5;

  localparam int unsigned SP_EXP  = 8;
  localparam int unsigned SP_FRAC = 23;
  localparam int unsigned DP_EXP  = 11;
  localparam int unsigned DP_FRAC = 52;
  localparam int unsigned SP_W    = SP_EXP + SP_FRAC + 1;
  localparam int unsigned DP_W    = DP_EXP + DP_FRAC + 1;

  // condition word bit positions (consumed by a neighbour, so fixed)
  localparam int unsigned C_UN   = 0;
  localparam int unsigned C_ORD  = 1;
  localparam int unsigned C_EQ   = 2;
  localparam int unsigned C_NE   = 3;
  localparam int unsigned C_GT   = 4;
  localparam int unsigned C_LE   = 5;
  localparam int unsigned C_LT   = 6;
  localparam int unsigned C_GE   = 7;
  localparam int unsigned C_OUT  = 8;
  localparam int unsigned C_OUTB = 11;
  localparam int unsigned C_UE   = 12;
  localparam int unsigned C_LG   = 13;
  localparam int unsigned C_UG   = 14;
  localparam int unsigned C_ULE  = 15;
  localparam int unsigned C_UL   = 16;
  localparam int unsigned C_UGE  = 17;
  localparam int unsigned EXT_LO = C_UE;
  localparam int unsigned EXT_HI = C_UGE;

  typedef enum logic [1:0] {
    REL_UN = 2'd0,
    REL_EQ = 2'd1,
    REL_LT = 2'd2,
    REL_GT = 2'd3
  } rel_e;

  typedef struct packed {
    logic           is_nan;
    logic           is_snan;
    logic           is_zero;
    logic           neg;
    logic [OPW-1:0] key;
  } op_info_t;

  // Expand a primary outcome into the full predicate set, rule by rule.
  function automatic logic [CW-1:0] fill_derived(input logic [CW-1:0] base);
    logic [CW-1:0] c;
    c = base;
    if (c[C_UN]) begin
      c[C_NE]  = 1'b1;
      c[C_UE]  = 1'b1;
      c[C_UG]  = 1'b1;
      c[C_ULE] = 1'b1;
      c[C_UL]  = 1'b1;
      c[C_UGE] = 1'b1;
    end
    if (c[C_EQ]) begin
      c[C_LE] = 1'b1;
      c[C_GE] = 1'b1;
      c[C_UE] = 1'b1;
    end
    if (c[C_GT]) c[C_GE] = 1'b1;
    if (c[C_LT]) c[C_LE] = 1'b1;
    if (c[C_LT] || c[C_GT]) c[C_LG] = 1'b1;
    if (c[C_LT] || c[C_GT] || c[C_EQ]) c[C_ORD] = 1'b1;
    if (c[C_GT]) c[C_UG]  = 1'b1;
    if (c[C_LE]) c[C_ULE] = 1'b1;
    if (c[C_LT]) c[C_UL]  = 1'b1;
    if (c[C_GE]) c[C_UGE] = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] val,
  output op_info_t              info
);

  localparam int unsigned W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              frac_nz;
  logic              low_frac_nz;

  // Sign-magnitude to an unsigned ordering key: negatives reversed below positives.
  function automatic logic [W-1:0] order_key(input logic [W-1:0] v);
    if (v[W-1]) return ~v;
    else        return {1'b1, v[W-2:0]};
  endfunction

  assign exp_f       = val[W-2:FRAC_W];
  assign frac_f      = val[FRAC_W-1:0];
  assign exp_max     = &exp_f;
  assign frac_nz     = |frac_f;
  assign low_frac_nz = |frac_f[FRAC_W-2:0];

  always_comb begin
    info.is_nan  = exp_max && frac_nz;
    info.is_snan = exp_max && !frac_f[FRAC_W-1] && low_frac_nz;
    info.is_zero = (exp_f == '0) && !frac_nz;
    info.neg     = val[W-1];
    info.key     = OPW'(order_key(val));
  end

endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
  import fcmp_pkg::*;
(
  input  logic           s1_nan,
  input  logic           s1_snan,
  input  logic           s1_zero,
  input  logic [OPW-1:0] s1_key,
  input  logic           s2_nan,
  input  logic           s2_snan,
  input  logic           s2_zero,
  input  logic [OPW-1:0] s2_key,
  input  logic           quiet,
  output rel_e           rel,
  output logic           invalid
);

  logic same_val;
  logic key_less;

  assign same_val = (s1_key == s2_key) || (s1_zero && s2_zero);
  assign key_less = s1_key < s2_key;

  // s1 is examined first; only the first NaN decides the flag
  always_comb begin
    if (s1_nan)      invalid = !quiet || s1_snan;
    else if (s2_nan) invalid = !quiet || s2_snan;
    else             invalid = 1'b0;
  end

  always_comb begin
    if (s1_nan || s2_nan) rel = REL_UN;
    else if (same_val)    rel = REL_EQ;
    else if (key_less)    rel = REL_LT;
    else                  rel = REL_GT;
  end

endmodule

// File: rtl/fcmp_interval.sv
module fcmp_interval
  import fcmp_pkg::*;
(
  input  rel_e       rel,
  input  logic       s1_zero,
  input  logic       s1_neg,
  input  logic       s2_neg,
  output logic [3:0] ivl      // {out_or_bound, inside, in_or_bound, outside}
);

  logic window_on;

  assign window_on = (rel != REL_UN) && !s2_neg;

  always_comb begin
    if (!window_on)                   ivl = 4'b0000;
    else if (rel == REL_EQ || s1_zero) ivl = 4'b1010;
    else if (rel == REL_GT)           ivl = 4'b1001;
    else if (!s1_neg)                 ivl = 4'b0110;
    else                              ivl = 4'b1001;
  end

endmodule

// File: rtl/fcmp_mask.sv
module fcmp_mask
  import fcmp_pkg::*;
(
  input  rel_e          rel,
  input  logic          legacy,
  input  logic [3:0]    ivl,
  output logic [CW-1:0] cond
);

  logic [CW-1:0] base;
  logic [CW-1:0] derived;

  always_comb begin
    base = '0;
    case (rel)
      REL_UN: base[C_UN] = 1'b1;
      REL_EQ: base[C_EQ] = 1'b1;
      REL_LT: begin base[C_LT] = 1'b1; base[C_NE] = 1'b1; end
      default: begin base[C_GT] = 1'b1; base[C_NE] = 1'b1; end
    endcase
  end

  assign derived = fill_derived(base);

  always_comb begin
    cond = derived;
    if (legacy) cond[EXT_HI:EXT_LO] = '0;
    cond[C_OUTB:C_OUT] = cond[C_OUTB:C_OUT] | ivl;
  end

endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
  import fcmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OPW-1:0]   s1_in,
  input  logic [OPW-1:0]   s2_in,
  input  logic             dbl_sel,
  input  logic             quiet_sel,
  input  logic             legacy_sel,
  input  logic [IDX_W-1:0] dst_idx,
  output logic [CW-1:0]    cond_word,
  output logic             invalid_flag,
  output logic             wr_en,
  output logic [IDX_W-1:0] dst_out
);

  localparam int unsigned NOPS = 2;

  logic [OPW-1:0] opnd    [NOPS];
  op_info_t       sp_info [NOPS];
  op_info_t       dp_info [NOPS];
  op_info_t       sel_info[NOPS];

  rel_e          rel_c;
  logic          invalid_c;
  logic [3:0]    ivl_c;
  logic [CW-1:0] cond_c;
  logic          dst_live;

  assign opnd[0] = s1_in;
  assign opnd[1] = s2_in;

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    fcmp_classify #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
      .val  (opnd[g][SP_W-1:0]),
      .info (sp_info[g])
    );
    fcmp_classify #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
      .val  (opnd[g][DP_W-1:0]),
      .info (dp_info[g])
    );
    assign sel_info[g] = dbl_sel ? dp_info[g] : sp_info[g];
  end

  fcmp_relate u_relate (
    .s1_nan  (sel_info[0].is_nan),
    .s1_snan (sel_info[0].is_snan),
    .s1_zero (sel_info[0].is_zero),
    .s1_key  (sel_info[0].key),
    .s2_nan  (sel_info[1].is_nan),
    .s2_snan (sel_info[1].is_snan),
    .s2_zero (sel_info[1].is_zero),
    .s2_key  (sel_info[1].key),
    .quiet   (quiet_sel),
    .rel     (rel_c),
    .invalid (invalid_c)
  );

  fcmp_interval u_interval (
    .rel     (rel_c),
    .s1_zero (sel_info[0].is_zero),
    .s1_neg  (sel_info[0].neg),
    .s2_neg  (sel_info[1].neg),
    .ivl     (ivl_c)
  );

  fcmp_mask u_mask (
    .rel    (rel_c),
    .legacy (legacy_sel),
    .ivl    (ivl_c),
    .cond   (cond_c)
  );

  assign dst_live = (dst_idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_word    <= '0;
      invalid_flag <= 1'b0;
      wr_en        <= 1'b0;
      dst_out      <= '0;
    end else begin
      invalid_flag <= in_valid && invalid_c;
      wr_en        <= in_valid && dst_live;
      if (in_valid) begin
        cond_word <= cond_c;
        dst_out   <= dst_idx;
      end
    end
  end

endmodule

// File: rtl/fcmp_cond_chk.sv
module fcmp_cond_chk
  import fcmp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             legacy_sel,
  input logic [IDX_W-1:0] dst_idx,
  input logic [CW-1:0]    cond_word,
  input logic             invalid_flag,
  input logic             wr_en,
  input logic [IDX_W-1:0] dst_out
);

  AST_UNORD_MASK: assert property (@(posedge clk) disable iff (rst)
    cond_word[C_UN] |-> (cond_word[C_OUTB:C_OUT] == 4'b0000 && cond_word[C_NE])); // R1

  AST_FLAG_NEEDS_NAN: assert property (@(posedge clk) disable iff (rst)
    invalid_flag |-> cond_word[C_UN]); // R2

  AST_ONE_PRIMARY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> $onehot({cond_word[C_UN], cond_word[C_EQ], cond_word[C_GT], cond_word[C_LT]})); // R3

  AST_LEGACY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legacy_sel) |=> (cond_word[EXT_HI:EXT_LO] == '0)); // R4

  AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_idx != '0) |=> (wr_en && dst_out == $past(dst_idx))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wr_en && !invalid_flag)); // R9

  AST_WE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (dst_out != '0)); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    cond_word[CW-1:EXT_HI+1] == '0); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cond_word == '0 && !wr_en && !invalid_flag && dst_out == '0)); // R10

endmodule

bind fcmp_cond_unit fcmp_cond_chk u_chk (.*);

// File: tb/test_fcmp_cond_unit.sv
module test_fcmp_cond_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] s1_in = '0;
  logic [63:0] s2_in = '0;
  logic        dbl_sel = 1'b0;
  logic        quiet_sel = 1'b0;
  logic        legacy_sel = 1'b0;
  logic [4:0]  dst_idx = '0;
  logic [31:0] cond_word;
  logic        invalid_flag;
  logic        wr_en;
  logic [4:0]  dst_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  fcmp_cond_unit i_fcmp_cond_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .s1_in(s1_in), .s2_in(s2_in),
    .dbl_sel(dbl_sel), .quiet_sel(quiet_sel), .legacy_sel(legacy_sel),
    .dst_idx(dst_idx), .cond_word(cond_word), .invalid_flag(invalid_flag),
    .wr_en(wr_en), .dst_out(dst_out)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference model: sign/magnitude reasoning, no ordering keys.
  function automatic logic [31:0] ref_word(input logic [63:0] a, input logic [63:0] b,
                                           input bit dbl, input bit quiet, input bit legacy,
                                           output bit inv);
    logic [62:0] ma, mb, inf;
    bit sa, sb, qa, qb, na, nb, za, zb, eq, lt, gt;
    logic [31:0] w;
    if (dbl) begin
      ma = a[62:0]; mb = b[62:0]; sa = a[63]; sb = b[63];
      inf = 63'h7FF0_0000_0000_0000; qa = a[51]; qb = b[51];
    end else begin
      ma = {32'd0, a[30:0]}; mb = {32'd0, b[30:0]}; sa = a[31]; sb = b[31];
      inf = 63'h0000_0000_7F80_0000; qa = a[22]; qb = b[22];
    end
    na = ma > inf;
    nb = mb > inf;
    inv = 1'b0;
    if (na)      inv = !quiet || !qa;
    else if (nb) inv = !quiet || !qb;
    za = (ma == 0);
    zb = (mb == 0);
    eq = 1'b0; lt = 1'b0; gt = 1'b0;
    if (na || nb) begin
      w = 32'h0003_D009;
    end else begin
      eq = (za && zb) || (sa == sb && ma == mb);
      if (!eq) begin
        if (sa != sb) lt = sa;
        else if (!sa) lt = ma < mb;
        else          lt = ma > mb;
      end
      gt = !eq && !lt;
      w = eq ? 32'h0002_90A6 : (lt ? 32'h0001_A06A : 32'h0002_609A);
    end
    if (legacy) w = w & ~32'h0003_F000;
    if (!(na || nb) && !sb) begin
      if (eq || za)  w = w | 32'h0000_0A00;
      else if (gt)   w = w | 32'h0000_0900;
      else if (!sa)  w = w | 32'h0000_0600;
      else           w = w | 32'h0000_0900;
    end
    return w;
  endfunction

  function automatic logic [63:0] pick(input bit dbl);
    logic [63:0] v;
    int k;
    v = {$urandom, $urandom};
    k = $urandom_range(0, 9);
    if (dbl) begin
      case (k)
        0: v = 64'h0000_0000_0000_0000;
        1: v = 64'h8000_0000_0000_0000;
        2: v = 64'h7FF0_0000_0000_0000;
        3: v = 64'hFFF0_0000_0000_0000;
        4: v = {v[63], 11'h7FF, 1'b1, v[50:0]};
        5: v = {v[63], 11'h7FF, 1'b0, v[50:1], 1'b1};
        6, 7: v = {v[63], 11'h3FF, 3'b000, v[48:0]};
        default: ;
      endcase
    end else begin
      case (k)
        0: v[31:0] = 32'h0000_0000;
        1: v[31:0] = 32'h8000_0000;
        2: v[31:0] = 32'h7F80_0000;
        3: v[31:0] = 32'hFF80_0000;
        4: v[31:0] = {v[31], 8'hFF, 1'b1, v[21:0]};
        5: v[31:0] = {v[31], 8'hFF, 1'b0, v[21:1], 1'b1};
        6, 7: v[31:0] = {v[31], 8'h7F, v[22:0]};
        default: ;
      endcase
    end
    return v;
  endfunction

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                        input bit quiet, input bit legacy, input logic [4:0] dst,
                        input string tag);
    logic [31:0] w;
    bit inv;
    @(negedge clk);
    s1_in = a; s2_in = b; dbl_sel = dbl; quiet_sel = quiet;
    legacy_sel = legacy; dst_idx = dst; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    w = ref_word(a, b, dbl, quiet, legacy, inv);
    chk(cond_word == w, tag, "cond_word", 64'(cond_word), 64'(w));
    chk(invalid_flag == inv, "R2", "invalid_flag", 64'(invalid_flag), 64'(inv));
    chk(wr_en == (dst != 0), "R9", "wr_en", 64'(wr_en), 64'(dst != 0));
    chk(dst_out == dst, "R9", "dst_out", 64'(dst_out), 64'(dst));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240607));

    // R10: reset clears outputs while a strobe is held high
    @(negedge clk);
    in_valid = 1'b1; s1_in = 64'h7FF8_0000_0000_0001; dst_idx = 5'd7; dbl_sel = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(cond_word == 0 && !wr_en && !invalid_flag && dst_out == 0, "R10", "reset outputs",
        {cond_word, 24'd0, wr_en, invalid_flag, 1'b0, dst_out}, 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // R3: basic single and double ordering, signed zeros, infinities
    run_op(64'h3F80_0000, 64'h4000_0000, 1'b0, 1'b0, 1'b0, 5'd3, "R3");
    run_op(64'h8000_0000, 64'h0000_0000, 1'b0, 1'b0, 1'b0, 5'd4, "R3");
    run_op(64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 5'd5, "R3");
    run_op(64'hFFF0_0000_0000_0000, 64'hBFF0_0000_0000_0000, 1'b1, 1'b0, 1'b0, 5'd6, "R3");
    // R6: s1 equal to s2, s1 zero of either sign
    run_op(64'h4000_0000, 64'h4000_0000, 1'b0, 1'b0, 1'b0, 5'd1, "R6");
    run_op(64'h8000_0000, 64'h4000_0000, 1'b0, 1'b0, 1'b0, 5'd1, "R6");
    run_op(64'h0, 64'h4000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 5'd1, "R6");
    // R7: above range, negative, strictly inside
    run_op(64'h4040_0000, 64'h4000_0000, 1'b0, 1'b0, 1'b0, 5'd2, "R7");
    run_op(64'hBF80_0000, 64'h4000_0000, 1'b0, 1'b0, 1'b0, 5'd2, "R7");
    run_op(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 5'd2, "R7");
    // R5: negative s2, including -0
    run_op(64'h3F80_0000, 64'hC000_0000, 1'b0, 1'b0, 1'b0, 5'd8, "R5");
    run_op(64'h3F80_0000, 64'h8000_0000, 1'b0, 1'b0, 1'b0, 5'd8, "R5");
    // R1 and R2: NaN pairings under both compare kinds
    run_op(64'h7FC0_0000, 64'h3F80_0000, 1'b0, 1'b0, 1'b0, 5'd9, "R1");
    run_op(64'h7FC0_0000, 64'h3F80_0000, 1'b0, 1'b1, 1'b0, 5'd9, "R2");
    run_op(64'h7FC0_0000, 64'h7F80_0001, 1'b0, 1'b1, 1'b0, 5'd9, "R2");
    run_op(64'h3F80_0000, 64'h7F80_0001, 1'b0, 1'b1, 1'b0, 5'd9, "R2");
    run_op(64'h7FF0_0000_0000_0001, 64'h0, 1'b1, 1'b1, 1'b0, 5'd9, "R2");
    // R4: legacy mode on ordered and unordered results
    run_op(64'h3F80_0000, 64'h4000_0000, 1'b0, 1'b0, 1'b1, 5'd10, "R4");
    run_op(64'h7FC0_0000, 64'h4000_0000, 1'b0, 1'b0, 1'b1, 5'd10, "R4");
    // R8: upper halves ignored in single precision
    run_op(64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_4000_0000, 1'b0, 1'b0, 1'b0, 5'd11, "R8");
    run_op(64'h7FF8_0000_4000_0000, 64'h1234_5678_4000_0000, 1'b0, 1'b0, 1'b0, 5'd11, "R8");
    // R9: zero destination, then idle behaviour
    run_op(64'h7FC0_0000, 64'h0, 1'b0, 1'b0, 1'b0, 5'd0, "R9");
    held = cond_word;
    @(negedge clk);
    chk(!wr_en && !invalid_flag, "R9", "idle pulses", {62'd0, wr_en, invalid_flag}, 64'd0);
    chk(cond_word == held && dst_out == 5'd0, "R9", "idle hold", 64'(cond_word), 64'(held));

    // Random mix
    for (int i = 0; i < 600; i++) begin
      bit dbl, quiet, legacy;
      logic [63:0] a, b;
      logic [31:0] w;
      bit inv;
      string tag;
      int mode;
      dbl = $urandom_range(0, 1);
      quiet = $urandom_range(0, 1);
      legacy = ($urandom_range(0, 3) == 0);
      a = pick(dbl);
      b = pick(dbl);
      mode = $urandom_range(0, 5);
      if (mode == 0) b = a;
      else if (mode == 1) b = dbl ? {~a[63], a[62:0]} : {a[63:32], ~a[31], a[30:0]};
      w = ref_word(a, b, dbl, quiet, legacy, inv);
      if (legacy) tag = "R4";
      else if (w[0]) tag = "R1";
      else if (w[11:8] == 0) tag = "R5";
      else tag = "R3";
      run_op(a, b, dbl, quiet, legacy, 5'($urandom), tag);
      chk(cond_word[31:18] == 0, "R9", "upper bits", 64'(cond_word[31:18]), 64'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule